// File: doc/BRIEF.md
# Parallel Bus Strobe Timing Engine

This engine drives the pins of an asynchronous, memory-style parallel bus: an active-low chip select, a six-bit address, active-low read and write strobes, and the enable and value of the data bus. A programmed transfer names a target device (one of four), a direction, an address and a word count. The engine then runs that many bus accesses. Each access moves one data word, taken from an upstream FIFO for writes and handed onward for reads.

Each access runs four timed phases in a fixed order. Setup holds address and select before the strobe. Strobe asserts the read or write strobe. Hold keeps select and address after the strobe is released. Pace is an idle gap with select released. All lengths are in core clock cycles and come from the setting bank that matches the target device and direction. A bank can skip setup on repeat accesses to an unchanged address. A bank can also impose its own pace gap on whatever access comes next, whichever device that access targets. A bank can also turn the two strobe pins into an enable pin plus a direction pin.

Top module: `pbus_strobe_engine`

## Requirements
- R1: While reset is held, and in the first cycle after it: chip select, read strobe and write strobe are high; data drive, busy, done, FIFO pop and read-valid are low.
- R2: Each access holds chip select low for exactly setup + strobe + hold cycles. The strobe is low for the strobe count, beginning right after the setup cycles.
- R3: A field value of zero encodes the maximum: 64 cycles for setup and hold, 128 cycles for strobe and pace. Any other value is the count itself.
- R4: Each bank occupies 31 bits, bank d at bits [31*d+30 : 31*d] of the read or write settings vector. Inside a bank: bit 30 alternate pin mode, bit 29 setup on first access only, bit 28 pace applies to next access, bits 27:26 width, bits 25:20 setup, bits 19:14 hold, bits 13:7 strobe, bits 6:0 pace. The bank is chosen by the device index and the direction.
- R5: While chip select is low, the address pins carry the address given with the start request and do not change.
- R6: With the first-only flag set, setup is skipped when the device and address equal those of the previously launched access, including one from an earlier program.
- R7: Between accesses, chip select stays high for at least the incoming bank's pace count. Within a program, with data available, the gap is exactly that count.
- R8: If the bank of the previous access had its pace-next flag set, that bank's pace count replaces the incoming bank's pace count for the gap.
- R9: A write access pops one FIFO word (tx_ready_o high for one cycle, only while tx_valid_i is high) as it launches. Chip select stays high while no word is offered. The data bus is driven, with the popped word, only during setup, strobe and hold of a write. It is never driven for reads.
- R10: For a read access, bus_din_i is sampled in the last strobe cycle. It appears on rx_data_o with rx_valid_o high for exactly the next cycle.
- R11: Width code 00 keeps data bits 7:0, 01 bits 15:0, 10 bits 17:0, 11 bits 8:0. The other bits read as zero, on both driven write data and returned read data.
- R12: In alternate pin mode, the read-strobe pin acts as the strobe for both directions. The write-strobe pin is low through setup, strobe and hold of a write, and high otherwise. In normal mode, only the strobe matching the direction ever goes low.
- R13: A program performs exactly its word count of accesses. done_o pulses for one cycle, in the cycle right after the last hold cycle. A start while busy, or with a count of zero, is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a program (accepted only when idle) |
| xfer_write_i | input | 1 | Program direction, 1 = write |
| xfer_dev_i | input | 2 | Target device / bank index |
| xfer_addr_i | input | 6 | Bus address for the program |
| xfer_len_i | input | 8 | Number of accesses |
| rd_cfg_i | input | 124 | Read setting banks, four packed banks |
| wr_cfg_i | input | 124 | Write setting banks, four packed banks |
| tx_data_i | input | 18 | Write word offered by the FIFO |
| tx_valid_i | input | 1 | FIFO has a write word |
| tx_ready_o | output | 1 | Pop of the offered write word |
| rx_data_o | output | 18 | Read word returned |
| rx_valid_o | output | 1 | rx_data_o is valid this cycle |
| bus_din_i | input | 18 | Data bus input value |
| bus_dout_o | output | 18 | Data bus output value |
| bus_doe_o | output | 1 | Data bus drive enable |
| bus_addr_o | output | 6 | Address pins |
| bus_cs_n_o | output | 1 | Chip select, active low |
| bus_oe_n_o | output | 1 | Read strobe / enable pin, active low |
| bus_we_n_o | output | 1 | Write strobe / direction pin, active low |
| busy_o | output | 1 | Program in progress |
| done_o | output | 1 | One-cycle program completion pulse |

## Verification
A start sampled at a clock edge leaves chip select high for one gap-evaluation cycle. The first access can launch no earlier than the cycle after that, and a done sampled in the same cycle as a new start therefore gives a cross-program gap of at least two cycles. The read word arrives one cycle after the last strobe cycle, and done arrives one cycle after the last hold cycle. The bench samples every pin on the falling edge and counts phase lengths in whole cycles from those samples, so each expected count (setup, strobe, hold, gap, lead-in) is compared to an exact number derived from the bank fields.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    localparam int CFG_W = 31;

    localparam logic [1:0] WID_8  = 2'b00;
    localparam logic [1:0] WID_16 = 2'b01;
    localparam logic [1:0] WID_18 = 2'b10;
    localparam logic [1:0] WID_9  = 2'b11;

    typedef struct packed {
        logic       alt_pins;
        logic       first_only;
        logic       pace_next;
        logic [1:0] width;
        logic [5:0] setup;
        logic [5:0] hold;
        logic [6:0] strobe;
        logic [6:0] pace;
    } bank_cfg_t;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_GAP    = 3'd1,
        PH_SETUP  = 3'd2,
        PH_STROBE = 3'd3,
        PH_HOLD   = 3'd4
    } phase_e;

    function automatic logic [7:0] len6(input logic [5:0] f);
        return (f == 6'd0) ? 8'd64 : {2'b00, f};
    endfunction

    function automatic logic [7:0] len7(input logic [6:0] f);
        return (f == 7'd0) ? 8'd128 : {1'b0, f};
    endfunction

endpackage

// File: rtl/pbus_bank_mux.sv
module pbus_bank_mux
    import pbus_pkg::*;
#(
    parameter int NDEV = 4
) (
    input  logic [NDEV*CFG_W-1:0]     rd_cfg_i,
    input  logic [NDEV*CFG_W-1:0]     wr_cfg_i,
    input  logic [$clog2(NDEV)-1:0]   dev_i,
    input  logic                      write_i,
    output bank_cfg_t                 cfg_o
);
    bank_cfg_t rd_bank [NDEV];
    bank_cfg_t wr_bank [NDEV];

    for (genvar g = 0; g < NDEV; g++) begin : g_unpack
        assign rd_bank[g] = bank_cfg_t'(rd_cfg_i[g*CFG_W +: CFG_W]);
        assign wr_bank[g] = bank_cfg_t'(wr_cfg_i[g*CFG_W +: CFG_W]);
    end

    always_comb begin
        cfg_o = write_i ? wr_bank[dev_i] : rd_bank[dev_i];
    end
endmodule

// File: rtl/pbus_lane_mask.sv
module pbus_lane_mask
    import pbus_pkg::*;
#(
    parameter int DATA_W = 18
) (
    input  logic [1:0]        width_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o
);
    localparam int L8  = (DATA_W < 8)  ? DATA_W : 8;
    localparam int L9  = (DATA_W < 9)  ? DATA_W : 9;
    localparam int L16 = (DATA_W < 16) ? DATA_W : 16;
    localparam int L18 = (DATA_W < 18) ? DATA_W : 18;

    localparam logic [DATA_W-1:0] ONES = {DATA_W{1'b1}};

    logic [DATA_W-1:0] lanes;

    always_comb begin
        unique case (width_i)
            WID_8:   lanes = ONES >> (DATA_W - L8);
            WID_16:  lanes = ONES >> (DATA_W - L16);
            WID_18:  lanes = ONES >> (DATA_W - L18);
            default: lanes = ONES >> (DATA_W - L9);
        endcase
        data_o = data_i & lanes;
    end
endmodule

// File: rtl/pbus_gap_tracker.sv
module pbus_gap_tracker (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       hold_end_i,
    input  logic       bus_idle_i,
    input  logic [7:0] pace_cur_i,
    input  logic       pace_next_cur_i,
    output logic       gap_met_o
);
    localparam logic [7:0] SAT = 8'hFF;

    typedef struct packed {
        logic [7:0] since;
        logic [7:0] owed;
        logic       owed_all;
    } gap_state_t;

    gap_state_t g_d, g_q;
    logic [7:0] need;

    always_comb begin
        g_d = g_q;
        if (hold_end_i) begin
            g_d.since    = 8'd1;
            g_d.owed     = pace_cur_i;
            g_d.owed_all = pace_next_cur_i;
        end else if (bus_idle_i && g_q.since != SAT) begin
            g_d.since = g_q.since + 8'd1;
        end
        need      = g_q.owed_all ? g_q.owed : pace_cur_i;
        gap_met_o = (g_q.since >= need);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            g_q.since    <= SAT;
            g_q.owed     <= 8'd0;
            g_q.owed_all <= 1'b0;
        end else begin
            g_q <= g_d;
        end
    end
endmodule

// File: rtl/pbus_strobe_engine.sv
module pbus_strobe_engine
    import pbus_pkg::*;
#(
    parameter int NDEV   = 4,
    parameter int ADDR_W = 6,
    parameter int DATA_W = 18,
    parameter int LEN_W  = 8
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        start_i,
    input  logic                        xfer_write_i,
    input  logic [$clog2(NDEV)-1:0]     xfer_dev_i,
    input  logic [ADDR_W-1:0]           xfer_addr_i,
    input  logic [LEN_W-1:0]            xfer_len_i,
    input  logic [NDEV*CFG_W-1:0]       rd_cfg_i,
    input  logic [NDEV*CFG_W-1:0]       wr_cfg_i,
    input  logic [DATA_W-1:0]           tx_data_i,
    input  logic                        tx_valid_i,
    output logic                        tx_ready_o,
    output logic [DATA_W-1:0]           rx_data_o,
    output logic                        rx_valid_o,
    input  logic [DATA_W-1:0]           bus_din_i,
    output logic [DATA_W-1:0]           bus_dout_o,
    output logic                        bus_doe_o,
    output logic [ADDR_W-1:0]           bus_addr_o,
    output logic                        bus_cs_n_o,
    output logic                        bus_oe_n_o,
    output logic                        bus_we_n_o,
    output logic                        busy_o,
    output logic                        done_o
);
    localparam int DEV_W = $clog2(NDEV);

    typedef struct packed {
        phase_e             phase;
        logic [7:0]         cnt;
        logic [LEN_W-1:0]   remain;
        logic [DEV_W-1:0]   dev;
        logic [ADDR_W-1:0]  addr;
        logic               wr;
        logic               last_vld;
        logic [DEV_W-1:0]   last_dev;
        logic [ADDR_W-1:0]  last_addr;
        logic [DATA_W-1:0]  wdata;
        logic [DATA_W-1:0]  rdata;
        logic               rvalid;
        logic               done;
    } eng_state_t;

    eng_state_t s_d, s_q;

    bank_cfg_t         cfg;
    logic [DATA_W-1:0] tx_masked;
    logic [DATA_W-1:0] rx_masked;
    logic              gap_met;
    logic              hold_end;
    logic              on_bus;
    logic              strobing;
    logic              skip_setup;
    logic              pop;

    pbus_bank_mux #(.NDEV(NDEV)) u_bank (
        .rd_cfg_i (rd_cfg_i),
        .wr_cfg_i (wr_cfg_i),
        .dev_i    (s_q.dev),
        .write_i  (s_q.wr),
        .cfg_o    (cfg)
    );

    pbus_lane_mask #(.DATA_W(DATA_W)) u_tx_mask (
        .width_i (cfg.width),
        .data_i  (tx_data_i),
        .data_o  (tx_masked)
    );

    pbus_lane_mask #(.DATA_W(DATA_W)) u_rx_mask (
        .width_i (cfg.width),
        .data_i  (bus_din_i),
        .data_o  (rx_masked)
    );

    pbus_gap_tracker u_gap (
        .clk_i           (clk_i),
        .rst_ni          (rst_ni),
        .hold_end_i      (hold_end),
        .bus_idle_i      (!on_bus),
        .pace_cur_i      (len7(cfg.pace)),
        .pace_next_cur_i (cfg.pace_next),
        .gap_met_o       (gap_met)
    );

    always_comb begin
        s_d        = s_q;
        s_d.rvalid = 1'b0;
        s_d.done   = 1'b0;
        hold_end   = 1'b0;
        pop        = 1'b0;
        skip_setup = cfg.first_only && s_q.last_vld &&
                     (s_q.last_dev == s_q.dev) && (s_q.last_addr == s_q.addr);

        unique case (s_q.phase)
            PH_IDLE: begin
                if (start_i && (xfer_len_i != '0)) begin
                    s_d.phase  = PH_GAP;
                    s_d.dev    = xfer_dev_i;
                    s_d.addr   = xfer_addr_i;
                    s_d.wr     = xfer_write_i;
                    s_d.remain = xfer_len_i;
                end
            end
            PH_GAP: begin
                if (gap_met && (!s_q.wr || tx_valid_i)) begin
                    pop           = s_q.wr;
                    s_d.wdata     = s_q.wr ? tx_masked : s_q.wdata;
                    s_d.last_vld  = 1'b1;
                    s_d.last_dev  = s_q.dev;
                    s_d.last_addr = s_q.addr;
                    if (skip_setup) begin
                        s_d.phase = PH_STROBE;
                        s_d.cnt   = len7(cfg.strobe);
                    end else begin
                        s_d.phase = PH_SETUP;
                        s_d.cnt   = len6(cfg.setup);
                    end
                end
            end
            PH_SETUP: begin
                if (s_q.cnt == 8'd1) begin
                    s_d.phase = PH_STROBE;
                    s_d.cnt   = len7(cfg.strobe);
                end else begin
                    s_d.cnt = s_q.cnt - 8'd1;
                end
            end
            PH_STROBE: begin
                if (s_q.cnt == 8'd1) begin
                    s_d.phase = PH_HOLD;
                    s_d.cnt   = len6(cfg.hold);
                    if (!s_q.wr) begin
                        s_d.rdata  = rx_masked;
                        s_d.rvalid = 1'b1;
                    end
                end else begin
                    s_d.cnt = s_q.cnt - 8'd1;
                end
            end
            PH_HOLD: begin
                if (s_q.cnt == 8'd1) begin
                    hold_end   = 1'b1;
                    s_d.remain = s_q.remain - 1'b1;
                    if (s_q.remain == {{(LEN_W-1){1'b0}}, 1'b1}) begin
                        s_d.phase = PH_IDLE;
                        s_d.done  = 1'b1;
                    end else begin
                        s_d.phase = PH_GAP;
                    end
                end else begin
                    s_d.cnt = s_q.cnt - 8'd1;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        on_bus   = (s_q.phase == PH_SETUP) || (s_q.phase == PH_STROBE) ||
                   (s_q.phase == PH_HOLD);
        strobing = (s_q.phase == PH_STROBE);

        bus_cs_n_o = !on_bus;
        bus_addr_o = s_q.addr;
        bus_doe_o  = on_bus && s_q.wr;
        bus_dout_o = s_q.wdata;
        if (cfg.alt_pins) begin
            bus_oe_n_o = !strobing;
            bus_we_n_o = !(on_bus && s_q.wr);
        end else begin
            bus_oe_n_o = !(strobing && !s_q.wr);
            bus_we_n_o = !(strobing && s_q.wr);
        end

        tx_ready_o = pop;
        rx_data_o  = s_q.rdata;
        rx_valid_o = s_q.rvalid;
        busy_o     = (s_q.phase != PH_IDLE);
        done_o     = s_q.done;
    end
endmodule

// File: rtl/pbus_strobe_engine_chk.sv
module pbus_strobe_engine_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              tx_valid_i,
    input logic              tx_ready_o,
    input logic              rx_valid_o,
    input logic              bus_doe_o,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic              bus_cs_n_o,
    input logic              bus_oe_n_o,
    input logic              bus_we_n_o,
    input logic              busy_o,
    input logic              done_o
);
    AST_STROBE_IN_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!bus_oe_n_o) |-> (!bus_cs_n_o)); // R2

    AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!bus_cs_n_o && $past(!bus_cs_n_o)) |-> $stable(bus_addr_o)); // R5

    AST_DRIVE_IN_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_doe_o |-> (!bus_cs_n_o)); // R9

    AST_POP_OFFERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_ready_o |-> tx_valid_i); // R9

    AST_POP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_ready_o |=> !tx_ready_o); // R9

    AST_RX_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_valid_o |=> !rx_valid_o); // R10

    AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R13

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> ($past(busy_o) && bus_cs_n_o)); // R13

    AST_WE_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_cs_n_o |-> bus_we_n_o); // R12
endmodule

bind pbus_strobe_engine pbus_strobe_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_valid_i (tx_valid_i),
    .tx_ready_o (tx_ready_o),
    .rx_valid_o (rx_valid_o),
    .bus_doe_o  (bus_doe_o),
    .bus_addr_o (bus_addr_o),
    .bus_cs_n_o (bus_cs_n_o),
    .bus_oe_n_o (bus_oe_n_o),
    .bus_we_n_o (bus_we_n_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
);

// File: tb/pbus_strobe_engine_tb.sv
`timescale 1ns/1ps
module pbus_strobe_engine_tb_top;
    localparam int CW = 31;
    localparam logic [17:0] TXD = 18'h2C3A5;
    localparam logic [17:0] DIN = 18'h1B7E9;

    // dev, wr, alt, addr, len, setup1, setup2, strobe, hold, gap, mask
    localparam int VT [0:7][0:10] = '{
        '{0, 0, 0, 5, 3,  2, 2,   3,  1, 2, 'hFFFF },
        '{0, 1, 0, 9, 2,  1, 1,   2,  2, 3, 'hFF   },
        '{1, 0, 0, 7, 3,  3, 0,   1,  2, 4, 'h3FFFF},
        '{1, 1, 0, 7, 2,  0, 0,   2,  1, 1, 'h1FF  },
        '{2, 0, 1, 3, 2,  1, 1,   2,  1, 2, 'hFF   },
        '{2, 1, 1, 4, 2,  2, 2,   3,  2, 1, 'hFFFF },
        '{3, 0, 0, 1, 1, 64, 0, 128, 64, 0, 'hFF   },
        '{3, 1, 0, 2, 2,  1, 1,   1,  1, 6, 'h3FFFF}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic xwr = 1'b0;
    logic [1:0] xdev = '0;
    logic [5:0] xaddr = '0;
    logic [7:0] xlen = '0;
    logic [4*CW-1:0] rd_cfg, wr_cfg;
    logic tx_valid = 1'b1;
    logic tx_ready, rx_valid, doe, cs_n, oe_n, we_n, busy, done;
    logic [17:0] rx_data, dout;
    logic [5:0] baddr;

    int checks = 0;
    int fails = 0;
    int wd = 0;

    always #2.5 clk = ~clk;

    function automatic logic [CW-1:0] mk(input bit alt, input bit fo, input bit pn,
        input int w, input int su, input int hd, input int st, input int pc);
        logic [CW-1:0] v;
        v = {alt, fo, pn, 2'(w), 6'(su), 6'(hd), 7'(st), 7'(pc)};
        return v;
    endfunction

    initial begin
        rd_cfg = {mk(0,0,0,0, 0, 0, 0,5), mk(1,0,0,0,1,1,2,2),
                  mk(0,1,0,2, 3, 2, 1,4), mk(0,0,0,1,2,1,3,2)};
        wr_cfg = {mk(0,0,1,2, 1, 1, 1,6), mk(1,0,0,1,2,2,3,1),
                  mk(0,1,0,3, 4, 1, 2,1), mk(0,0,0,0,1,2,2,3)};
    end

    pbus_strobe_engine dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .xfer_write_i(xwr),
        .xfer_dev_i(xdev), .xfer_addr_i(xaddr), .xfer_len_i(xlen),
        .rd_cfg_i(rd_cfg), .wr_cfg_i(wr_cfg), .tx_data_i(TXD),
        .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .rx_data_o(rx_data),
        .rx_valid_o(rx_valid), .bus_din_i(DIN), .bus_dout_o(dout),
        .bus_doe_o(doe), .bus_addr_o(baddr), .bus_cs_n_o(cs_n),
        .bus_oe_n_o(oe_n), .bus_we_n_o(we_n), .busy_o(busy), .done_o(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
            summary();
        end
    end

    task automatic run_prog(input int dev, input int wr, input int alt, input int addr,
        input int len, input int es1, input int es2, input int estr, input int ehold,
        input int egap, input int mask, input int elead, input int poke);
        int n = 0, s1 = 0, s2 = 0, str1 = 0, hd1 = 0, gp1 = 0, lead = 0;
        int pops = 0, rxs = 0, derr = 0, aerr = 0, perr = 0, dones = 0, cyc = 0;
        bit in_cs = 0, seen = 0, ended = 0;
        logic [17:0] m;
        m = 18'(mask);
        xdev = 2'(dev); xwr = wr[0]; xaddr = 6'(addr); xlen = 8'(len);
        start = 1'b1;
        while (!ended && cyc < 3000) begin
            @(negedge clk);
            if (cyc == 0) start = 1'b0;
            if (poke != 0 && cyc == 3) begin xlen = 8'(poke); start = 1'b1; end
            if (poke != 0 && cyc == 4) start = 1'b0;
            cyc++;
            if (!cs_n) begin
                bit strb;
                strb = !oe_n || (alt == 0 && !we_n);
                if (!in_cs) begin n++; in_cs = 1; seen = 0; end
                if (baddr !== 6'(addr)) aerr++;
                if (doe !== wr[0]) derr++;
                if (wr != 0 && doe && dout !== (TXD & m)) derr++;
                if (alt != 0 && we_n !== !wr[0]) perr++;
                if (alt == 0 && wr != 0 && !oe_n) perr++;
                if (alt == 0 && wr == 0 && !we_n) perr++;
                if (strb) begin
                    seen = 1;
                    if (n == 1) str1++;
                end else if (!seen) begin
                    if (n == 1) s1++;
                    if (n == 2) s2++;
                end else if (n == 1) hd1++;
            end else begin
                in_cs = 0;
                if (n == 0) lead++;
                if (n == 1) gp1++;
            end
            if (tx_ready) pops++;
            if (rx_valid) begin
                rxs++;
                if (rx_data !== (DIN & m)) derr++;
            end
            if (done) begin dones++; ended = 1; end
        end
        chk(n == len, "R13", "access count", n, len);
        chk(dones == 1, "R13", "done pulses", dones, 1);
        chk(s1 == es1, "R2 R3 R6", "first setup cycles", s1, es1);
        if (len >= 2) chk(s2 == es2, "R6", "second setup cycles", s2, es2);
        chk(str1 == estr, "R2 R3 R4", "strobe cycles", str1, estr);
        chk(hd1 == ehold, "R2 R3", "hold cycles", hd1, ehold);
        if (len >= 2) chk(gp1 == egap, "R7", "pace gap", gp1, egap);
        if (wr != 0) chk(pops == len, "R9", "pops", pops, len);
        else chk(rxs == len, "R10", "read words", rxs, len);
        chk(derr == 0, "R9 R10 R11", "data errors", derr, 0);
        chk(aerr == 0, "R5", "address errors", aerr, 0);
        chk(perr == 0, "R12", "pin mode errors", perr, 0);
        if (elead >= 0) chk(lead + 1 == elead, "R8", "lead-in gap", lead + 1, elead);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(cs_n && oe_n && we_n && !doe && !busy && !done && !tx_ready && !rx_valid,
            "R1", "outputs in reset", {cs_n, oe_n, we_n, doe, busy}, 5'b11100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n && oe_n && we_n && !doe && !busy && !done,
            "R1", "outputs after reset", {cs_n, oe_n, we_n, doe, busy}, 5'b11100);

        for (int i = 0; i < 8; i++) begin
            run_prog(VT[i][0], VT[i][1], VT[i][2], VT[i][3], VT[i][4], VT[i][5],
                     VT[i][6], VT[i][7], VT[i][8], VT[i][9], VT[i][10], -1, 0);
        end

        // R8: previous bank (dev3 write, pace-next, pace 6) governs
        run_prog(0, 0, 0, 5, 1, 2, 0, 3, 1, 0, 'hFFFF, 6, 0);
        // R7: no pace-next, incoming dev1 read pace 4 governs
        run_prog(1, 0, 0, 8, 1, 3, 0, 1, 2, 0, 'h3FFFF, 4, 0);
        // R13: start while busy is ignored
        run_prog(0, 1, 0, 9, 2, 1, 1, 2, 2, 3, 'hFF, -1, 5);

        // R13: zero count ignored
        begin
            int act = 0;
            xlen = 8'd0; xwr = 1'b0; xdev = 2'd0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            for (int k = 0; k < 8; k++) begin
                if (busy || !cs_n || done) act++;
                @(negedge clk);
            end
            chk(act == 0, "R13", "zero-count start activity", act, 0);
        end

        // R9: write waits with select high while FIFO is empty
        begin
            int act = 0, low = 0;
            tx_valid = 1'b0;
            repeat (10) @(negedge clk);
            xlen = 8'd1; xwr = 1'b1; xdev = 2'd0; xaddr = 6'd12;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            for (int k = 0; k < 10; k++) begin
                if (!cs_n || tx_ready || doe) act++;
                @(negedge clk);
            end
            chk(act == 0, "R9", "activity while FIFO empty", act, 0);
            tx_valid = 1'b1;
            for (int k = 0; k < 40 && !done; k++) begin
                @(negedge clk);
                if (!cs_n) low++;
            end
            chk(low == 5, "R9", "select cycles after data arrives", low, 5);
        end

        summary();
    end
endmodule